// File: doc/BRIEF.md
# Shadow Tag Set with Life Countdown

This block holds a small array of shadow entries for one sampled cache set. When the cache replacement logic bypasses a fill, or evicts a block from a position other than the least-recently-used one, it may record that block here. Each recorded entry keeps a partial address tag, the identifier of the instruction that brought the block in, a life counter and a valid bit. If the same address is requested again while the entry is still alive, the replacement decision was wrong, and the predictor can use the reported instruction identifier and life value to correct itself.

Every access to the shadowed cache set presents its tag for lookup and ages the array. Each valid entry's life drops by one on every access. An entry expires when its life reaches zero, and it is consumed on a hit. The lookup result is combinational and uses the state before that access's aging. The cache line is still fetched from the next level on a shadow hit; this block stores no data. The array holds half as many entries as the cache set has ways.

Top module: `shadow_tag_set`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until an entry has been inserted.
- R2: While `acc_valid` is high, `hit` is high in the same cycle when a valid entry's tag equals `acc_tag`. `hit_pc` and `hit_life` then show that entry's instruction identifier and its life before this access's aging. If several entries match, the lowest-index entry is reported. `hit` is low whenever `acc_valid` is low.
- R3: An entry that hits is invalidated at the end of that access, so a repeated lookup of the same tag misses.
- R4: Each cycle with `acc_valid` high lowers the life of every valid entry by one. Cycles without an access leave all lives and valid bits unchanged.
- R5: An entry whose life is 1 when an access occurs becomes invalid at the end of that access.
- R6: `ins_src` encodes the insertion source. 2'b00 is a bypassed fill and 2'b01 is a victim from a non-LRU position; both are stored. 2'b10 is a plain LRU victim and 2'b11 is reserved; both are ignored and change no entry.
- R7: An insertion with `ins_life` equal to 0 is ignored.
- R8: An accepted insertion writes the lowest-index invalid entry. If every entry is valid, it overwrites the entry with the smallest life, taking the lowest index on a tie. The choice is made on the state before the cycle's updates.
- R9: When an insertion and an access fall in the same cycle, the new entry is not visible to that cycle's lookup and is not aged by that access. It starts with exactly `ins_life`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access to the shadowed cache set this cycle (lookup and aging) |
| acc_tag | input | TAG_W | Partial address tag of the access |
| hit | output | 1 | Lookup matched a live entry |
| hit_pc | output | PC_W | Instruction identifier of the matching entry |
| hit_life | output | $clog2(CACHE_WAYS)+1 | Pre-aging life of the matching entry |
| ins_valid | input | 1 | Insertion request |
| ins_src | input | 2 | Insertion source code (see R6) |
| ins_tag | input | TAG_W | Partial address tag to record |
| ins_pc | input | PC_W | Identifier of the inserting instruction |
| ins_life | input | $clog2(CACHE_WAYS)+1 | Expected LRU position, used as the initial life |

## Verification
Three things can happen to an entry in the same cycle: an access that hits it and ages the rest, an insertion that fills a slot, and an expiry when a life runs out. The bench forces these overlaps. It inserts a tag in the very cycle that the same tag is looked up, and it fills the array while other entries are hitting or expiring. A behavioural model, built from queues of entries with an ordered victim rule, predicts `hit`, `hit_pc` and `hit_life` every cycle and judges each overlap.

// File: rtl/shd_pkg.sv
package shd_pkg;

   // Insertion source codes; only the first two are recorded.
   typedef enum logic [1:0] {
      SRC_BYPASS = 2'b00,
      SRC_NONLRU = 2'b01,
      SRC_LRU    = 2'b10,
      SRC_RSVD   = 2'b11
   } ins_src_e;

   function automatic logic src_is_recorded(input logic [1:0] s);
      return (s == SRC_BYPASS) || (s == SRC_NONLRU);
   endfunction

endpackage

// File: rtl/shd_entry.sv
module shd_entry #(
   parameter int TAG_W  = 16,
   parameter int PC_W   = 15,
   parameter int LIFE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              age,
   input  logic              kill,
   input  logic              load,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [PC_W-1:0]   ld_pc,
   input  logic [LIFE_W-1:0] ld_life,
   output logic              vld,
   output logic [TAG_W-1:0]  tag,
   output logic [PC_W-1:0]   pc,
   output logic [LIFE_W-1:0] life
);

   localparam logic [LIFE_W-1:0] ONE = LIFE_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         tag  <= '0;
         pc   <= '0;
         life <= '0;
      end else if (load) begin
         vld  <= 1'b1;
         tag  <= ld_tag;
         pc   <= ld_pc;
         life <= ld_life;
      end else if (vld) begin
         if (kill) begin
            vld <= 1'b0;
         end else if (age) begin
            if (life == ONE) vld <= 1'b0;
            life <= life - ONE;
         end
      end
   end

endmodule

// File: rtl/shd_match.sv
module shd_match #(
   parameter int N     = 4,
   parameter int TAG_W = 16
) (
   input  logic                    en,
   input  logic [TAG_W-1:0]        key,
   input  logic [N-1:0]            vld,
   input  logic [N-1:0][TAG_W-1:0] tags,
   output logic                    any,
   output logic [N-1:0]            sel
);

   logic [N-1:0] raw;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign raw[i] = en && vld[i] && (tags[i] == key);
   end

   // Lowest index wins.
   always_comb begin
      sel = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (raw[i]) sel = N'(1) << i;
      end
   end

   assign any = |raw;

endmodule

// File: rtl/shd_victim_pick.sv
module shd_victim_pick #(
   parameter int N      = 4,
   parameter int LIFE_W = 4
) (
   input  logic [N-1:0]             vld,
   input  logic [N-1:0][LIFE_W-1:0] life,
   output logic [N-1:0]             victim
);

   logic [N-1:0] free_sel;
   logic [N-1:0] min_sel;
   logic [LIFE_W-1:0] min_val;

   always_comb begin
      free_sel = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!vld[i]) free_sel = N'(1) << i;
      end
   end

   always_comb begin
      min_sel = N'(1);
      min_val = life[0];
      for (int i = 1; i < N; i++) begin
         if (life[i] < min_val) begin
            min_val = life[i];
            min_sel = N'(1) << i;
         end
      end
   end

   assign victim = (|free_sel) ? free_sel : min_sel;

endmodule

// File: rtl/shadow_tag_set.sv
module shadow_tag_set #(
   parameter int CACHE_WAYS = 8,
   parameter int TAG_W      = 16,
   parameter int PC_W       = 15
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          acc_valid,
   input  logic [TAG_W-1:0]              acc_tag,
   output logic                          hit,
   output logic [PC_W-1:0]               hit_pc,
   output logic [$clog2(CACHE_WAYS):0]   hit_life,
   input  logic                          ins_valid,
   input  logic [1:0]                    ins_src,
   input  logic [TAG_W-1:0]              ins_tag,
   input  logic [PC_W-1:0]               ins_pc,
   input  logic [$clog2(CACHE_WAYS):0]   ins_life
);

   import shd_pkg::*;

   localparam int LIFE_W = $clog2(CACHE_WAYS) + 1;
   localparam int N_ENT  = CACHE_WAYS / 2;

   if (CACHE_WAYS < 2 || (CACHE_WAYS & (CACHE_WAYS - 1)) != 0) begin : g_bad_ways
      $error("CACHE_WAYS must be a power of two of at least 2");
   end
   if (TAG_W < 1 || PC_W < 1) begin : g_bad_width
      $error("TAG_W and PC_W must be positive");
   end

   logic [N_ENT-1:0]             vld_q;
   logic [N_ENT-1:0][TAG_W-1:0]  tag_q;
   logic [N_ENT-1:0][PC_W-1:0]   pc_q;
   logic [N_ENT-1:0][LIFE_W-1:0] life_q;
   logic [N_ENT-1:0]             hit_sel;
   logic [N_ENT-1:0]             victim;
   logic                         ins_take;

   assign ins_take = ins_valid && src_is_recorded(ins_src) && (ins_life != '0);

   shd_match #(.N(N_ENT), .TAG_W(TAG_W)) i_match (
      .en   (acc_valid),
      .key  (acc_tag),
      .vld  (vld_q),
      .tags (tag_q),
      .any  (hit),
      .sel  (hit_sel)
   );

   shd_victim_pick #(.N(N_ENT), .LIFE_W(LIFE_W)) i_pick (
      .vld    (vld_q),
      .life   (life_q),
      .victim (victim)
   );

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      shd_entry #(.TAG_W(TAG_W), .PC_W(PC_W), .LIFE_W(LIFE_W)) i_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .age     (acc_valid),
         .kill    (hit_sel[i]),
         .load    (ins_take && victim[i]),
         .ld_tag  (ins_tag),
         .ld_pc   (ins_pc),
         .ld_life (ins_life),
         .vld     (vld_q[i]),
         .tag     (tag_q[i]),
         .pc      (pc_q[i]),
         .life    (life_q[i])
      );
   end

   // One-hot read-out of the matching entry.
   always_comb begin
      hit_pc   = '0;
      hit_life = '0;
      for (int i = 0; i < N_ENT; i++) begin
         hit_pc   = hit_pc   | ({PC_W{hit_sel[i]}}   & pc_q[i]);
         hit_life = hit_life | ({LIFE_W{hit_sel[i]}} & life_q[i]);
      end
   end

endmodule

// File: rtl/shd_checker.sv
module shd_checker #(
   parameter int N  = 4,
   parameter int LW = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 acc_valid,
   input logic                 hit,
   input logic [LW-1:0]        hit_life,
   input logic                 ins_valid,
   input logic [1:0]           ins_src,
   input logic [N-1:0]         vld,
   input logic [N-1:0][LW-1:0] life
);

   logic [N-1:0] dead_live;
   always_comb begin
      for (int i = 0; i < N; i++) dead_live[i] = vld[i] && (life[i] == '0);
   end

   a_r2_hit_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> acc_valid);

   a_r2_hit_life_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (hit_life != '0));

   a_r3_hit_frees_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ins_valid) |=> ($countones(vld) < $past($countones(vld))));

   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && !ins_valid) |=> ($stable(vld) && $stable(life)));

   a_r5_no_live_zero: assert property (@(posedge clk) disable iff (!rst_n)
      dead_live == '0);

   a_r6_lru_victim_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_src[1] && !acc_valid) |=> $stable(vld));

   a_r8_one_slot_per_insert: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(vld) <= $past($countones(vld)) + 1));

endmodule

bind shadow_tag_set shd_checker #(.N(N_ENT), .LW(LIFE_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .hit       (hit),
   .hit_life  (hit_life),
   .ins_valid (ins_valid),
   .ins_src   (ins_src),
   .vld       (vld_q),
   .life      (life_q)
);

// File: tb/test_shadow_tag_set.sv
module test_shadow_tag_set;

   localparam int CLK_PERIOD = 10;
   localparam int WAYS  = 8;
   localparam int TAG_W = 16;
   localparam int PC_W  = 15;
   localparam int LW    = $clog2(WAYS) + 1;
   localparam int NE    = WAYS / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0;
   logic [TAG_W-1:0] acc_tag = '0;
   logic hit;
   logic [PC_W-1:0] hit_pc;
   logic [LW-1:0] hit_life;
   logic ins_valid = 1'b0;
   logic [1:0] ins_src = 2'b00;
   logic [TAG_W-1:0] ins_tag = '0;
   logic [PC_W-1:0] ins_pc = '0;
   logic [LW-1:0] ins_life = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shadow_tag_set #(.CACHE_WAYS(WAYS), .TAG_W(TAG_W), .PC_W(PC_W)) i_shadow_tag_set (
      .clk, .rst_n, .acc_valid, .acc_tag, .hit, .hit_pc, .hit_life,
      .ins_valid, .ins_src, .ins_tag, .ins_pc, .ins_life
   );

   // Behavioural model: an ordered list of slots.
   int m_vld[NE];
   int m_tag[NE];
   int m_pc[NE];
   int m_life[NE];

   function automatic int m_find(int t);
      for (int i = 0; i < NE; i++) if (m_vld[i] != 0 && m_tag[i] == t) return i;
      return -1;
   endfunction

   function automatic int m_victim();
      int best;
      for (int i = 0; i < NE; i++) if (m_vld[i] == 0) return i;
      best = 0;
      for (int i = 1; i < NE; i++) if (m_life[i] < m_life[best]) best = i;
      return best;
   endfunction

   task automatic check(string req, int ok, string what, int act, int exp);
      n_chk++;
      if (ok == 0) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(string req, int acc, int atag, int ins, int src,
                       int itag, int ipc, int ilife);
      int h;
      int v;
      int take;
      @(negedge clk);
      acc_valid = (acc != 0);
      acc_tag   = TAG_W'(atag);
      ins_valid = (ins != 0);
      ins_src   = 2'(src);
      ins_tag   = TAG_W'(itag);
      ins_pc    = PC_W'(ipc);
      ins_life  = LW'(ilife);
      #1;
      h = (acc != 0) ? m_find(atag) : -1;
      check(req, int'(hit) == ((h >= 0) ? 1 : 0), "hit", int'(hit), (h >= 0) ? 1 : 0);
      if (h >= 0 && hit) begin
         check(req, int'(hit_pc) == m_pc[h], "hit_pc", int'(hit_pc), m_pc[h]);
         check(req, int'(hit_life) == m_life[h], "hit_life", int'(hit_life), m_life[h]);
      end
      v = m_victim();
      take = (ins != 0) && (src == 0 || src == 1) && (ilife != 0);
      @(posedge clk);
      for (int i = 0; i < NE; i++) begin
         if (take != 0 && i == v) begin
            m_vld[i] = 1; m_tag[i] = itag; m_pc[i] = ipc; m_life[i] = ilife;
         end else if (m_vld[i] != 0) begin
            if (i == h) m_vld[i] = 0;
            else if (acc != 0) begin
               if (m_life[i] == 1) m_vld[i] = 0;
               m_life[i]--;
            end
         end
      end
   endtask

   task automatic look(string req, int t);
      step(req, 1, t, 0, 0, 0, 0, 0);
   endtask

   task automatic put(string req, int src, int t, int p, int l);
      step(req, 0, 0, 1, src, t, p, l);
   endtask

   task automatic drain();
      for (int i = 0; i < WAYS + 1; i++) look("R5", 16'hFFFF);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < NE; i++) begin
         m_vld[i] = 0; m_tag[i] = 0; m_pc[i] = 0; m_life[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: nothing hits after reset
      look("R1", 0);
      look("R1", 16'h1234);

      // R2 / R3: lookup returns pc and life, then consumes the entry
      put("R2", 0, 16'h00A1, 7, 3);
      look("R2", 16'h00A1);
      look("R3", 16'h00A1);

      // R5: expiry when life runs out
      put("R5", 1, 16'h00B2, 9, 2);
      look("R5", 16'h0777);
      look("R5", 16'h0777);
      look("R5", 16'h00B2);

      // R4: aging per access, frozen without access
      put("R4", 0, 16'h00C3, 11, 5);
      look("R4", 16'h0777);
      step("R4", 0, 0, 0, 0, 0, 0, 0);
      step("R4", 0, 0, 0, 0, 0, 0, 0);
      step("R4", 0, 0, 0, 0, 0, 0, 0);
      look("R4", 16'h00C3);
      drain();

      // R6: source codes
      put("R6", 2, 16'h00E4, 1, 4);
      look("R6", 16'h00E4);
      put("R6", 3, 16'h00E5, 2, 4);
      look("R6", 16'h00E5);
      put("R6", 1, 16'h00F6, 3, 4);
      look("R6", 16'h00F6);

      // R7: zero life insertion dropped
      put("R7", 0, 16'h0107, 4, 0);
      look("R7", 16'h0107);
      drain();

      // R8: full array replacement picks smallest life, lowest index
      put("R8", 0, 16'h0200, 20, 6);
      put("R8", 0, 16'h0201, 21, 3);
      put("R8", 0, 16'h0202, 22, 3);
      put("R8", 0, 16'h0203, 23, 7);
      put("R8", 0, 16'h0204, 24, 5);
      look("R8", 16'h0201);
      look("R8", 16'h0202);
      look("R8", 16'h0204);
      look("R8", 16'h0200);
      drain();

      // R9: insert and look up the same tag in one cycle
      step("R9", 1, 16'h0309, 1, 0, 16'h0309, 30, 4);
      look("R9", 16'h0309);
      // R9 / R3: hit on one entry while another is inserted
      put("R9", 0, 16'h030A, 31, 5);
      step("R9", 1, 16'h030A, 1, 1, 16'h030B, 32, 2);
      look("R9", 16'h030B);
      drain();

      // Mixed traffic over a small tag space (R2, R8)
      for (int k = 0; k < 3000; k++) begin
         step("R8", int'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 32767)),
              int'($urandom_range(0, WAYS)));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule